// File: doc/BRIEF.md
# Four-Channel Buffered PWM Generator

This block drives four pulse-width modulated outputs. A simple memory-mapped register bus controls it: a write strobe, a read strobe, a 12-bit address and 32-bit write and read data. Each channel divides the system clock by a power of two and runs a 16-bit period counter. The output of a channel is inactive at the start of every period and turns active once the counter reaches the duty value. The duty value therefore sets the length of the *inactive* part of each period.

Software changes a running waveform through buffer registers. A value written to a buffer is held and is copied into the live duty or period register only when the running period ends, so no period is ever cut short or stretched part-way through. A global flag register records, per channel, that a period has ended, and reading it clears it. Software uses that flag to learn that a buffered value has been taken on.

Enable and disable are bit masks written to two global addresses. A disabled channel finishes the period it is in before it stops, so a final duty setting is always applied to a whole period.

Top module: `pwm_quad`

## Requirements
- R1: After reset every register reads zero, no channel runs, and every output is low.
- R2: A write to 0x04 starts each idle channel whose data bit (bit c for channel c) is one. A write to 0x08 asks each running channel whose bit is one to stop. Zero bits change nothing. Bits 3:0 of a read at 0x0C show which channels are running.
- R3: A running channel's counter starts at 0 in the cycle after the enable write. It advances on each prescaled tick and wraps after reaching period minus one; a period value of 0 acts as 1. The raw level is active while the counter is at or above the duty value. So a duty of 0 is always active, and a duty at or above the period is never active.
- R4: Bits 3:0 of a channel's mode register (channel offset 0x00) select a tick every 2^n clocks. Values from 11 to 15 behave as 10. The register reads back as written.
- R5: Bit 9 of the mode register inverts the output pin, both while running and while idle.
- R6: Writes to the duty buffer (channel offset 0x08) and the period buffer (offset 0x10) read back at once. They reach the live registers only at the next period end. If a buffer write lands on the same edge as that period end, the buffer keeps the new value and stays pending.
- R7: Writes to the live duty register (offset 0x04) and the live period register (offset 0x0C) take effect from the next cycle, even while the channel runs.
- R8: After a stop request the channel runs on to the end of its current period. It then stops, its counter returns to zero, its output goes to the idle level and its running bit clears. An enable written before that period end cancels the stop.
- R9: At the edge where a channel's period ends, bit c of the flag register at 0x1C is set. A read of 0x1C clears all bits at the clock edge after the read. A period end on that same edge still sets its bit.
- R10: Channel c's registers sit at 0x200 + 0x20*c. Reads of the enable and disable addresses, and of every unmapped address, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one transfer per cycle |
| busRdEn | input | 1 | Read strobe; clears the flag register when reading 0x1C |
| busAddr | input | 12 | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the current address, combinational |
| pwmOut | output | 4 | Channel outputs |

## Verification
The bench aims at these edges:
- Buffered writes that land just before, on, or after a period end. A design that loads buffers early would glitch the running period. One that drops the pending mark would lose the new value.
- A stop request that arrives in the last cycle of a period, and an enable that cancels a pending stop. A wrong design would stop mid-period or fail to restart.
- A flag read that coincides with a period end. A design that gives clear priority over set would lose that event.
- The prescaler clamp for mode values above 10, and duty values of zero, equal to the period and past the period. Off-by-one compares would show as an extra or missing active cycle.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  // Width of the counter, duty and period fields
  localparam int VAL_W = 16;
  // Width of the prescaler select field in the mode register
  localparam int SEL_W = 4;
  // Bit position of the output inversion control in the mode register
  localparam int INV_BIT = 9;

  // Global addresses (software decodes these)
  localparam int OFS_ENABLE  = 'h004;
  localparam int OFS_DISABLE = 'h008;
  localparam int OFS_RUN     = 'h00C;
  localparam int OFS_FLAG    = 'h01C;

  // Channel register groups
  localparam int CH_BASE   = 'h200;
  localparam int STRIDE_SH = 5;
  localparam int CH_STRIDE = 1 << STRIDE_SH;

  // Offsets inside one channel group
  localparam int OFS_MODE     = 'h00;
  localparam int OFS_DUTY     = 'h04;
  localparam int OFS_DUTY_BUF = 'h08;
  localparam int OFS_PER      = 'h0C;
  localparam int OFS_PER_BUF  = 'h10;

  // Strobes from the register control to one channel datapath
  typedef struct packed {
    logic start;
    logic stop;
    logic modeWr;
    logic dutyWr;
    logic dutyBufWr;
    logic perWr;
    logic perBufWr;
  } chanStrobe_t;

  // State a channel exposes for status, flags and readback
  typedef struct packed {
    logic             running;
    logic             periodEnd;
    logic             invert;
    logic [SEL_W-1:0] prescSel;
    logic [VAL_W-1:0] duty;
    logic [VAL_W-1:0] dutyBuf;
    logic [VAL_W-1:0] period;
    logic [VAL_W-1:0] periodBuf;
  } chanView_t;

endpackage

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busWrEn,
  input  logic                     busRdEn,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [DATA_W-1:0]        busWrData,
  input  chanView_t [NUM_CH-1:0]   views,
  output chanStrobe_t [NUM_CH-1:0] strobes,
  output logic [DATA_W-1:0]        busRdData
);

  localparam int IDX_W = $clog2(NUM_CH);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CH_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(NUM_CH * CH_STRIDE);

  logic [ADDR_W-1:0]    relAddr;
  logic                 inChan;
  logic [IDX_W-1:0]     chanIdx;
  logic [STRIDE_SH-1:0] regOff;
  logic                 isEna, isDis, isRun, isFlag;
  logic [NUM_CH-1:0]    chanHit, runVec, endVec, flags;
  logic                 flagRead;
  chanView_t            selView;
  logic                 unusedWrHi;

  assign unusedWrHi = ^busWrData[DATA_W-1:NUM_CH];

  // Address decode
  assign relAddr = busAddr - BASE_A;
  assign inChan  = (busAddr >= BASE_A) && (relAddr < SPAN_A);
  assign chanIdx = relAddr[STRIDE_SH +: IDX_W];
  assign regOff  = relAddr[STRIDE_SH-1:0];
  assign isEna   = busAddr == ADDR_W'(OFS_ENABLE);
  assign isDis   = busAddr == ADDR_W'(OFS_DISABLE);
  assign isRun   = busAddr == ADDR_W'(OFS_RUN);
  assign isFlag  = busAddr == ADDR_W'(OFS_FLAG);
  assign flagRead = busRdEn && isFlag;

  // Per-channel strobe generation
  for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
    assign chanHit[c] = inChan && (chanIdx == IDX_W'(c));
    assign strobes[c].start     = busWrEn && isEna && busWrData[c];
    assign strobes[c].stop      = busWrEn && isDis && busWrData[c];
    assign strobes[c].modeWr    = busWrEn && chanHit[c] && (regOff == STRIDE_SH'(OFS_MODE));
    assign strobes[c].dutyWr    = busWrEn && chanHit[c] && (regOff == STRIDE_SH'(OFS_DUTY));
    assign strobes[c].dutyBufWr = busWrEn && chanHit[c] && (regOff == STRIDE_SH'(OFS_DUTY_BUF));
    assign strobes[c].perWr     = busWrEn && chanHit[c] && (regOff == STRIDE_SH'(OFS_PER));
    assign strobes[c].perBufWr  = busWrEn && chanHit[c] && (regOff == STRIDE_SH'(OFS_PER_BUF));
    assign runVec[c] = views[c].running;
    assign endVec[c] = views[c].periodEnd;
  end

  // Period-end flags: a read clears them, a new period end always sets its bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flagRead ? '0 : flags) | endVec;
  end

  // Read multiplexer
  always_comb begin
    busRdData = '0;
    selView   = views[chanIdx];
    if (isRun) begin
      busRdData[NUM_CH-1:0] = runVec;
    end else if (isFlag) begin
      busRdData[NUM_CH-1:0] = flags;
    end else if (inChan) begin
      case (regOff)
        STRIDE_SH'(OFS_MODE): begin
          busRdData[SEL_W-1:0] = selView.prescSel;
          busRdData[INV_BIT]   = selView.invert;
        end
        STRIDE_SH'(OFS_DUTY):     busRdData[VAL_W-1:0] = selView.duty;
        STRIDE_SH'(OFS_DUTY_BUF): busRdData[VAL_W-1:0] = selView.dutyBuf;
        STRIDE_SH'(OFS_PER):      busRdData[VAL_W-1:0] = selView.period;
        STRIDE_SH'(OFS_PER_BUF):  busRdData[VAL_W-1:0] = selView.periodBuf;
        default:                  busRdData = '0;
      endcase
    end
  end

  // R9: a flag read with no new period end leaves every flag clear
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (flagRead && endVec == '0) |=> (flags == '0))
    else $error("flag register not cleared by read");

  // R9: every period end is recorded, even on a clearing read
  p_flag_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (endVec != '0) |=> ((flags & $past(endVec)) == $past(endVec)))
    else $error("period end event lost");

  // R10: an address selects at most one channel group
  p_one_chan_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanHit))
    else $error("overlapping channel decode");

endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
  import pwm_quad_pkg::*;
#(
  parameter int PRESC_MAX = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobe_t      strobe,
  input  logic [VAL_W-1:0] wrVal,
  output chanView_t        view,
  output logic             pwmOut
);

  localparam int PC_W = PRESC_MAX;
  localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(PRESC_MAX);

  logic             running, stopReq, invert;
  logic [SEL_W-1:0] prescSel, effSel;
  logic [PC_W-1:0]  prescCnt, tickMask;
  logic [VAL_W-1:0] cnt, duty, dutyBuf, period, periodBuf;
  logic             dutyPend, perPend;
  logic             tick, endPer, stopping, rawActive;

  // Prescaler: tick when the low effSel bits of the free counter are all ones
  assign effSel   = (prescSel > SEL_LIMIT) ? SEL_LIMIT : prescSel;
  assign tickMask = (PC_W'(1) << effSel) - PC_W'(1);
  assign tick     = running && ((prescCnt & tickMask) == tickMask);

  // Period end: last count reached (a zero period ends on every tick)
  assign endPer   = tick && (({1'b0, cnt} + 1'b1) >= {1'b0, period});
  assign stopping = endPer && stopReq && !strobe.start;

  // Inactive first, active from the duty count on
  assign rawActive = running && (cnt >= duty);
  assign pwmOut    = rawActive ^ invert;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      stopReq   <= 1'b0;
      invert    <= 1'b0;
      prescSel  <= '0;
      prescCnt  <= '0;
      cnt       <= '0;
      duty      <= '0;
      dutyBuf   <= '0;
      period    <= '0;
      periodBuf <= '0;
      dutyPend  <= 1'b0;
      perPend   <= 1'b0;
    end else begin
      if (!running) begin
        if (strobe.start) begin
          running  <= 1'b1;
          stopReq  <= 1'b0;
          cnt      <= '0;
          prescCnt <= '0;
        end
      end else begin
        prescCnt <= prescCnt + 1'b1;
        if (tick) cnt <= endPer ? '0 : cnt + 1'b1;
        if (strobe.start)     stopReq <= 1'b0;
        else if (strobe.stop) stopReq <= 1'b1;
        if (stopping) begin
          running  <= 1'b0;
          stopReq  <= 1'b0;
          cnt      <= '0;
          prescCnt <= '0;
        end
      end
      // Buffered values are adopted at the period boundary
      if (endPer && dutyPend) begin
        duty     <= dutyBuf;
        dutyPend <= 1'b0;
      end
      if (endPer && perPend) begin
        period  <= periodBuf;
        perPend <= 1'b0;
      end
      // Bus writes take priority over the boundary load
      if (strobe.dutyWr) duty <= wrVal;
      if (strobe.perWr)  period <= wrVal;
      if (strobe.dutyBufWr) begin
        dutyBuf  <= wrVal;
        dutyPend <= 1'b1;
      end
      if (strobe.perBufWr) begin
        periodBuf <= wrVal;
        perPend   <= 1'b1;
      end
      if (strobe.modeWr) begin
        prescSel <= wrVal[SEL_W-1:0];
        invert   <= wrVal[INV_BIT];
      end
    end
  end

  assign view.running   = running;
  assign view.periodEnd = endPer;
  assign view.invert    = invert;
  assign view.prescSel  = prescSel;
  assign view.duty      = duty;
  assign view.dutyBuf   = dutyBuf;
  assign view.period    = period;
  assign view.periodBuf = periodBuf;

  // R8: a channel only stops at a period boundary
  p_stop_on_boundary_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(endPer))
    else $error("channel stopped mid-period");

  // R8: an idle channel holds its counter at zero
  p_idle_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (cnt == '0))
    else $error("idle channel counter not zero");

  // R3: a new period opens at the inactive level unless duty is zero
  p_start_inactive_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(endPer) && running && duty != '0) |-> !rawActive)
    else $error("period did not start inactive");

  // R6: live duty only moves at a boundary or on a direct write
  p_hold_duty_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!endPer && !strobe.dutyWr) |=> $stable(duty))
    else $error("duty changed mid-period");

  // R6: live period only moves at a boundary or on a direct write
  p_hold_period_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!endPer && !strobe.perWr) |=> $stable(period))
    else $error("period changed mid-period");

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int PRESC_MAX = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_CH-1:0] pwmOut
);

  chanStrobe_t [NUM_CH-1:0] strobes;
  chanView_t   [NUM_CH-1:0] views;

  pwm_quad_ctrl #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .views     (views),
    .strobes   (strobes),
    .busRdData (busRdData)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    pwm_quad_chan #(
      .PRESC_MAX (PRESC_MAX)
    ) u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobes[g]),
      .wrVal  (busWrData[VAL_W-1:0]),
      .view   (views[g]),
      .pwmOut (pwmOut[g])
    );
  end

endmodule

// File: tb/pwm_quad_tb_top.sv
module pwm_quad_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [3:0]  pwmOut;

  int    nChecks = 0;
  int    nFail = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  always #10 clk = ~clk;  // 50 MHz

  pwm_quad dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .pwmOut    (pwmOut)
  );

  // Reference model built from the requirements
  logic [3:0]  mRun, mStop, mInv, mDP, mPP, mFlag;
  logic [3:0]  mSel  [4];
  logic [9:0]  mPc   [4];
  logic [15:0] mCnt  [4];
  logic [15:0] mDuty [4];
  logic [15:0] mDBuf [4];
  logic [15:0] mPer  [4];
  logic [15:0] mPBuf [4];

  function automatic bit chanWrite(input int c, input int off);
    return busWrEn && (int'(busAddr) == 'h200 + 32 * c + off);
  endfunction

  always @(posedge clk) begin
    logic [3:0] ends;
    if (!rstN) begin
      mRun = 0; mStop = 0; mInv = 0; mDP = 0; mPP = 0; mFlag = 0;
      for (int c = 0; c < 4; c++) begin
        mSel[c] = 0; mPc[c] = 0; mCnt[c] = 0; mDuty[c] = 0;
        mDBuf[c] = 0; mPer[c] = 0; mPBuf[c] = 0;
      end
    end else begin
      ends = 0;
      for (int c = 0; c < 4; c++) begin
        int eff;
        int msk;
        bit tk, en, sEna, sDis, stopNow;
        eff  = (mSel[c] > 10) ? 10 : int'(mSel[c]);
        msk  = (1 << eff) - 1;
        tk   = mRun[c] && ((int'(mPc[c]) & msk) == msk);
        en   = tk && (int'(mCnt[c]) + 1 >= int'(mPer[c]));
        sEna = busWrEn && busAddr == 12'h004 && busWrData[c];
        sDis = busWrEn && busAddr == 12'h008 && busWrData[c];
        stopNow = en && mStop[c] && !sEna;
        ends[c] = en;
        if (!mRun[c]) begin
          if (sEna) begin
            mRun[c] = 1; mStop[c] = 0; mCnt[c] = 0; mPc[c] = 0;
          end
        end else begin
          mPc[c] = mPc[c] + 1;
          if (tk) mCnt[c] = en ? 16'd0 : mCnt[c] + 1;
          if (sEna) mStop[c] = 0;
          else if (sDis) mStop[c] = 1;
          if (stopNow) begin
            mRun[c] = 0; mStop[c] = 0; mCnt[c] = 0; mPc[c] = 0;
          end
        end
        if (en && mDP[c]) begin mDuty[c] = mDBuf[c]; mDP[c] = 0; end
        if (en && mPP[c]) begin mPer[c] = mPBuf[c]; mPP[c] = 0; end
        if (chanWrite(c, 'h04)) mDuty[c] = busWrData[15:0];
        if (chanWrite(c, 'h0C)) mPer[c] = busWrData[15:0];
        if (chanWrite(c, 'h08)) begin mDBuf[c] = busWrData[15:0]; mDP[c] = 1; end
        if (chanWrite(c, 'h10)) begin mPBuf[c] = busWrData[15:0]; mPP[c] = 1; end
        if (chanWrite(c, 'h00)) begin mSel[c] = busWrData[3:0]; mInv[c] = busWrData[9]; end
      end
      mFlag = ((busRdEn && busAddr == 12'h01C) ? 4'd0 : mFlag) | ends;
    end
  end

  function automatic logic [3:0] expPwm();
    logic [3:0] v;
    for (int c = 0; c < 4; c++)
      v[c] = (mRun[c] && (mCnt[c] >= mDuty[c])) ^ mInv[c];
    return v;
  endfunction

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    logic [31:0] v;
    int c, off;
    v = '0;
    if (a == 12'h00C) v[3:0] = mRun;
    else if (a == 12'h01C) v[3:0] = mFlag;
    else if (a >= 12'h200 && a < 12'h280) begin
      c   = int'(a - 12'h200) / 32;
      off = int'(a - 12'h200) % 32;
      case (off)
        'h00: begin v[3:0] = mSel[c]; v[9] = mInv[c]; end
        'h04: v[15:0] = mDuty[c];
        'h08: v[15:0] = mDBuf[c];
        'h0C: v[15:0] = mPer[c];
        'h10: v[15:0] = mPBuf[c];
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s at %0t: actual=%h expected=%h", curReq, what, $time, act, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, then compare outputs
  task automatic cyc(input bit wr, input bit rd, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = wr; busRdEn = rd; busAddr = a; busWrData = d;
    #2;
    check("pwmOut", {28'd0, pwmOut}, {28'd0, expPwm()});
    check("busRdData", busRdData, modelRead(a));
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b0, a, d);
  endtask

  task automatic rdReg(input logic [11:0] a);
    cyc(1'b0, 1'b1, a, 32'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 12'h00C, 32'd0);
  endtask

  function automatic logic [11:0] chAddr(input int c, input int off);
    return 12'('h200 + 32 * c + off);
  endfunction

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    curReq = "R1";  // everything reads zero after reset
    rdReg(12'h00C);
    rdReg(12'h01C);
    for (int c = 0; c < 4; c++)
      for (int o = 0; o <= 'h10; o += 4) rdReg(chAddr(c, o));

    curReq = "R10";  // write-only and unmapped addresses read zero
    rdReg(12'h000); rdReg(12'h004); rdReg(12'h008); rdReg(12'h010);
    rdReg(12'h214); rdReg(12'h202); rdReg(12'h280); rdReg(12'h3E0); rdReg(12'hFFC);

    curReq = "R2";  // enable masks, zero bits inert
    wrReg(chAddr(0, 'h04), 2);  wrReg(chAddr(0, 'h0C), 5);
    wrReg(chAddr(1, 'h04), 0);  wrReg(chAddr(1, 'h0C), 4);
    wrReg(chAddr(2, 'h04), 3);  wrReg(chAddr(2, 'h0C), 3);
    wrReg(12'h004, 32'h5);
    idle(3);
    wrReg(12'h004, 32'h0);
    wrReg(12'h008, 32'h0);
    rdReg(12'h00C);
    wrReg(12'h004, 32'h2);

    curReq = "R3";  // waveform shapes incl. duty 0 and duty == period
    idle(25);

    curReq = "R4";  // prescaler, then clamped select 13
    wrReg(chAddr(3, 'h00), 2);
    wrReg(chAddr(3, 'h0C), 3);
    wrReg(chAddr(3, 'h04), 1);
    wrReg(12'h004, 32'h8);
    idle(40);
    wrReg(12'h008, 32'h8);
    idle(14);
    wrReg(chAddr(3, 'h00), 13);
    rdReg(chAddr(3, 'h00));
    wrReg(chAddr(3, 'h0C), 2);
    wrReg(12'h004, 32'h8);
    idle(4200);
    wrReg(12'h008, 32'h8);
    idle(2100);

    curReq = "R5";  // inversion while running and when idle
    wrReg(chAddr(2, 'h00), 32'h200);
    idle(10);
    wrReg(12'h008, 32'h4);
    idle(10);

    curReq = "R6";  // buffered duty and period
    wrReg(chAddr(0, 'h08), 4);
    wrReg(chAddr(0, 'h10), 7);
    rdReg(chAddr(0, 'h08));
    rdReg(chAddr(0, 'h10));
    idle(16);

    curReq = "R7";  // direct live writes
    wrReg(chAddr(1, 'h04), 2);
    idle(8);
    wrReg(chAddr(1, 'h0C), 6);
    idle(8);

    curReq = "R8";  // stop at period end, enable cancels stop
    wrReg(12'h008, 32'h1);
    for (int i = 0; i < 10; i++) rdReg(12'h00C);
    wrReg(12'h008, 32'h2);
    wrReg(12'h004, 32'h2);
    idle(12);
    rdReg(12'h00C);

    curReq = "R9";  // clear-on-read flags
    for (int i = 0; i < 10; i++) rdReg(12'h01C);
    idle(6);
    rdReg(12'h01C);
    rdReg(12'h01C);

    curReq = "R3";  // mixed random traffic against the model
    for (int i = 0; i < 15000; i++) begin
      int r, c;
      r = int'($urandom % 100);
      c = int'($urandom % 4);
      if (r < 50) idle(1);
      else if (r < 56) rdReg(12'h01C);
      else if (r < 62) rdReg(chAddr(c, 4 * int'($urandom % 5)));
      else if (r < 70) wrReg(12'h004, $urandom % 16);
      else if (r < 75) wrReg(12'h008, $urandom % 16);
      else if (r < 80) wrReg(chAddr(c, 'h00),
                             ($urandom & 32'hFFFF_FDF0) | ($urandom % 3) | (($urandom % 2) << 9));
      else if (r < 87) wrReg(chAddr(c, 'h08), $urandom % 14);
      else if (r < 93) wrReg(chAddr(c, 'h10), $urandom % 13);
      else if (r < 97) wrReg(chAddr(c, 'h04), $urandom % 14);
      else wrReg(chAddr(c, 'h0C), $urandom % 13);
    end
    idle(4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(100000 * 20);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL %s watchdog: actual=hung expected=finished", curReq);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule